// File: doc/BRIEF.md
# Trimmed-Mean Oscillator Code Filter

This block sits beside the tracking controller of an all-digital clock recovery loop. It takes the oscillator control codes the controller issues and keeps a steady baseline code. When the sign of the phase error flips, the controller reloads the oscillator from this baseline instead of its last code. The baseline therefore reflects the recent centre of the code stream, and a single outlier cannot drag it.

Accepted codes shift into a window that holds the four most recent values. The first baseline appears once four codes have been accepted since reset or clear. After that, a new baseline is computed after every second accepted code. Each computation runs through a fixed pipeline. A compare-swap network sorts the window, the largest and smallest entries are dropped, and the two remaining middle values are averaged with truncation. A clear input restarts the sample count, cancels any computation in flight and invalidates the baseline.

Top module: `code_trim_filter`

## Requirements
- R1: While rst_ni is low, and after its release until a baseline is formed, baseline_o is 0 and baseline_valid_o is 0.
- R2: baseline_valid_o stays 0 until four codes have been accepted since reset or the last clear. The fourth accepted code starts the first computation.
- R3: A computed baseline equals the truncated mean of the two middle values of the four most recent accepted codes, (a+b)>>1. The largest and smallest codes are dropped, with ties treated as ordinary values.
- R4: After the first baseline, a new computation starts on every second accepted code (the 6th, 8th, 10th code and so on). Codes in between leave baseline_o unchanged.
- R5: baseline_o and baseline_valid_o take the new result on the second rising edge after the edge that accepts the triggering code, which is a three-edge latency counting the accepting edge. Codes accepted during that latency do not alter the result.
- R6: The window keeps only the four most recent accepted codes. Each computation after the first uses the two newest codes together with the two codes accepted before them.
- R7: clear_i high at a rising edge sets baseline_o to 0 and baseline_valid_o to 0 at that edge. It restarts the count of accepted codes and cancels any computation in flight. A code offered in the same cycle as clear_i is not accepted.
- R8: Once baseline_valid_o is 1 it stays 1 until clear_i or reset, and baseline_o holds its value while no computation completes.
- R9: code_i is ignored in any cycle where code_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of count, window use and baseline |
| code_valid_i | input | 1 | code_i carries a code this cycle |
| code_i | input | 11 | Oscillator control code from the tracking controller |
| baseline_o | output | 11 | Trimmed-mean baseline code |
| baseline_valid_o | output | 1 | baseline_o holds a computed value |

## Verification
A wrong sample count shows at the ports as a baseline that appears one code early or late, or as an update on an odd-numbered code. The bench sees this at the first baseline after a clear and at every later pair. A fault in the window or the sort network gives a wrong value within three cycles of the triggering code. The sweep over all tuples of edge values, including ties and both range limits, exposes swapped or dropped lanes. A pipeline valid that leaks past clear makes a baseline appear when none is expected, and this shows two cycles after the clear.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
  typedef enum logic {
    FILLING  = 1'b0,
    TRACKING = 1'b1
  } ctf_phase_e;
endpackage

// File: rtl/ctf_sequencer.sv
module ctf_sequencer #(
  parameter int DEPTH  = 4,
  parameter int STRIDE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic code_valid_i,
  output logic accept_o,
  output logic trig_q_o
);
  import ctf_pkg::*;

  localparam int FILL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int STR_W  = (STRIDE > 1) ? $clog2(STRIDE) : 1;
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(DEPTH - 1);
  localparam logic [STR_W-1:0]  STR_LAST  = STR_W'(STRIDE - 1);

  ctf_phase_e        phase_q;
  logic [FILL_W-1:0] fill_q;
  logic [STR_W-1:0]  stride_q;
  logic              trig;

  assign accept_o = code_valid_i && !clear_i;
  assign trig     = accept_o && ((phase_q == TRACKING) ? (stride_q == STR_LAST)
                                                       : (fill_q == FILL_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= FILLING;
      fill_q   <= '0;
      stride_q <= '0;
      trig_q_o <= 1'b0;
    end else if (clear_i) begin
      phase_q  <= FILLING;
      fill_q   <= '0;
      stride_q <= '0;
      trig_q_o <= 1'b0;
    end else begin
      trig_q_o <= trig;
      if (accept_o) begin
        if (phase_q == FILLING) begin
          if (fill_q == FILL_LAST) begin
            phase_q  <= TRACKING;
            stride_q <= '0;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end else begin
          stride_q <= (stride_q == STR_LAST) ? '0 : stride_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctf_window.sv
module ctf_window #(
  parameter int CODE_W = 11,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] win_o [DEPTH]
);
  // slot 0 newest, slot DEPTH-1 oldest
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_o[k] <= '0;
      end else if (push_i) begin
        if (k == 0) win_o[k] <= code_i;
        else        win_o[k] <= win_o[(k > 0) ? k - 1 : 0];
      end
    end
  end
endmodule

// File: rtl/ctf_sort_net.sv
module ctf_sort_net #(
  parameter int CODE_W = 11,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              go_i,
  input  logic [CODE_W-1:0] win_i [DEPTH],
  output logic              go_o,
  output logic [CODE_W-1:0] sorted_o [DEPTH]
);
  // odd-even transposition: DEPTH stages, ascending order
  logic [CODE_W-1:0] net [DEPTH+1][DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_in
    assign net[0][j] = win_i[j];
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    for (genvar j = 0; j < DEPTH; j++) begin : g_lane
      if (((j % 2) == (s % 2)) && ((j + 1) < DEPTH)) begin : g_lo
        assign net[s+1][j] = (net[s][j+1] < net[s][j]) ? net[s][j+1] : net[s][j];
      end else if (((j % 2) != (s % 2)) && (j >= 1)) begin : g_hi
        assign net[s+1][j] = (net[s][j-1] > net[s][j]) ? net[s][j-1] : net[s][j];
      end else begin : g_pass
        assign net[s+1][j] = net[s][j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o <= 1'b0;
      for (int j = 0; j < DEPTH; j++) sorted_o[j] <= '0;
    end else begin
      go_o <= go_i && !clear_i;
      if (go_i) begin
        for (int j = 0; j < DEPTH; j++) sorted_o[j] <= net[DEPTH][j];
      end
    end
  end
endmodule

// File: rtl/ctf_trim_avg.sv
module ctf_trim_avg #(
  parameter int CODE_W = 11,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              go_i,
  input  logic [CODE_W-1:0] sorted_i [DEPTH],
  output logic [CODE_W-1:0] baseline_o,
  output logic              baseline_valid_o
);
  localparam int KEEP  = DEPTH - 2;
  localparam int SUM_W = CODE_W + $clog2(DEPTH);

  logic [SUM_W-1:0]  sum;
  logic [CODE_W-1:0] mean;

  always_comb begin
    sum = '0;
    for (int j = 1; j < DEPTH - 1; j++) sum = sum + SUM_W'(sorted_i[j]);
  end

  assign mean = CODE_W'(sum / SUM_W'(KEEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baseline_o       <= '0;
      baseline_valid_o <= 1'b0;
    end else if (clear_i) begin
      baseline_o       <= '0;
      baseline_valid_o <= 1'b0;
    end else if (go_i) begin
      baseline_o       <= mean;
      baseline_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/code_trim_filter.sv
module code_trim_filter #(
  parameter int CODE_W = 11,
  parameter int DEPTH  = 4,
  parameter int STRIDE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] baseline_o,
  output logic              baseline_valid_o
);
  logic              accept;
  logic              sort_go;
  logic              avg_go;
  logic [CODE_W-1:0] win    [DEPTH];
  logic [CODE_W-1:0] sorted [DEPTH];

  ctf_sequencer #(.DEPTH(DEPTH), .STRIDE(STRIDE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .code_valid_i(code_valid_i),
    .accept_o    (accept),
    .trig_q_o    (sort_go)
  );

  ctf_window #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(accept),
    .code_i(code_i),
    .win_o (win)
  );

  ctf_sort_net #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_sort (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .go_i    (sort_go),
    .win_i   (win),
    .go_o    (avg_go),
    .sorted_o(sorted)
  );

  ctf_trim_avg #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_avg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .clear_i         (clear_i),
    .go_i            (avg_go),
    .sorted_i        (sorted),
    .baseline_o      (baseline_o),
    .baseline_valid_o(baseline_valid_o)
  );
endmodule

// File: rtl/ctf_chk.sv
module ctf_chk #(
  parameter int CODE_W = 11,
  parameter int DEPTH  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              code_valid_i,
  input logic [CODE_W-1:0] baseline_o,
  input logic              baseline_valid_o,
  input logic              avg_go_i
);
  localparam int SEEN_W = $clog2(DEPTH + 1) + 1;
  localparam logic [SEEN_W-1:0] SEEN_MAX = {SEEN_W{1'b1}};

  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   seen_q <= '0;
    else if (clear_i)                              seen_q <= '0;
    else if (code_valid_i && seen_q != SEEN_MAX)   seen_q <= seen_q + 1'b1;
  end

  // R2
  early_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baseline_valid_o |-> (seen_q >= SEEN_W'(DEPTH)));

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!baseline_valid_o && (baseline_o == '0)));

  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baseline_valid_o && !clear_i) |=> baseline_valid_o);

  // R4
  baseline_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(baseline_o) |-> ($past(avg_go_i) || $past(clear_i)));

  // R5
  result_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_go_i && !clear_i) |=> baseline_valid_o);
endmodule

bind code_trim_filter ctf_chk #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_ctf_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clear_i         (clear_i),
  .code_valid_i    (code_valid_i),
  .baseline_o      (baseline_o),
  .baseline_valid_o(baseline_valid_o),
  .avg_go_i        (avg_go)
);

// File: tb/tb_code_trim_filter.sv
`timescale 1ns/1ps
module tb_code_trim_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        code_valid_i = 1'b0;
  logic [10:0] code_i = '0;
  logic [10:0] baseline_o;
  logic        baseline_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int hist [4];
  int m_cnt = 0;
  int exp_base = 0;
  int exp_valid = 0;

  always #5 clk_i = ~clk_i;

  code_trim_filter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .code_valid_i(code_valid_i), .code_i(code_i),
    .baseline_o(baseline_o), .baseline_valid_o(baseline_valid_o)
  );

  function automatic int trim4(int a, int b, int c, int d);
    int mx, mn;
    mx = a; mn = a;
    if (b > mx) mx = b; if (c > mx) mx = c; if (d > mx) mx = d;
    if (b < mn) mn = b; if (c < mn) mn = c; if (d < mn) mn = d;
    return (a + b + c + d - mx - mn) / 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag);
    chk({tag, " baseline"}, int'(baseline_o), exp_base);
    chk({tag, " valid"}, int'(baseline_valid_o), exp_valid);
  endtask

  task automatic push(int c);
    bit trig;
    code_i = 11'(c);
    code_valid_i = 1'b1;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = c;
    m_cnt++;
    trig = (m_cnt == 4) || (m_cnt > 4 && (m_cnt % 2) == 0);
    @(negedge clk_i);
    code_valid_i = 1'b0;
    code_i = 11'($urandom % 2048);  // R9 garbage while idle
    chk_out((m_cnt < 4) ? "R2 before four" : "R4 hold");
    @(negedge clk_i);
    chk_out("R5 not yet");
    if (trig) begin
      @(negedge clk_i);
      exp_base = trim4(hist[0], hist[1], hist[2], hist[3]);
      exp_valid = 1;
      chk_out((m_cnt > 4) ? "R6 sliding" : "R3 first");
    end
  endtask

  task automatic do_clear(bit with_code, int c);
    clear_i = 1'b1;
    code_valid_i = with_code;
    code_i = 11'(c);
    @(negedge clk_i);
    clear_i = 1'b0;
    code_valid_i = 1'b0;
    m_cnt = 0;
    exp_base = 0;
    exp_valid = 0;
    chk_out("R7 clear");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int vals [4];
    int v [6];
    vals = '{0, 1, 1024, 2047};
    for (int k = 0; k < 4; k++) hist[k] = 0;

    // R1
    repeat (3) @(negedge clk_i);
    chk_out("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_out("R1 after release");

    // R3 R6: all tuples over edge values, incl. ties and range limits
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            do_clear(1'b0, 0);
            push(vals[a]); push(vals[b]); push(vals[c]); push(vals[d]);
          end

    // R4 R6 R9: long stream with sliding pairs
    do_clear(1'b0, 0);
    for (int i = 0; i < 1200; i++) push(int'($urandom % 2048));

    // R8: idle keeps baseline
    repeat (50) begin
      code_i = 11'($urandom % 2048);
      @(negedge clk_i);
    end
    chk_out("R8 idle hold");

    // R7: code offered with clear is not accepted
    do_clear(1'b1, 2000);
    push(10); push(20); push(30);
    chk_out("R7 same-cycle code ignored");
    push(40);
    chk("R7 count after clear", int'(baseline_o), 25);

    // R7: clear cancels computation in flight
    do_clear(1'b0, 0);
    push(100); push(200); push(300);
    code_i = 11'd400;
    code_valid_i = 1'b1;
    @(negedge clk_i);
    code_valid_i = 1'b0;
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    m_cnt = 0; exp_base = 0; exp_valid = 0;
    @(negedge clk_i);
    chk_out("R7 in-flight cancel");
    @(negedge clk_i);
    chk_out("R7 in-flight cancel late");

    // R5: back-to-back codes, results land after fixed latency
    do_clear(1'b0, 0);
    for (int k = 0; k < 6; k++) v[k] = int'($urandom % 2048);
    for (int k = 0; k < 6; k++) begin
      code_i = 11'(v[k]);
      code_valid_i = 1'b1;
      @(negedge clk_i);
      if (k == 4) chk("R5 burst early", int'(baseline_valid_o), 0);
    end
    code_valid_i = 1'b0;
    chk("R5 burst first", int'(baseline_o), trim4(v[0], v[1], v[2], v[3]));
    chk("R5 burst valid", int'(baseline_valid_o), 1);
    @(negedge clk_i);
    chk("R5 burst hold", int'(baseline_o), trim4(v[0], v[1], v[2], v[3]));
    @(negedge clk_i);
    chk("R5 burst second", int'(baseline_o), trim4(v[2], v[3], v[4], v[5]));

    done = 1'b1;
    finish_run();
  end
endmodule